// File: doc/BRIEF.md
# Port Pin-Change Interrupt Controller

This block watches a port of general-purpose pins and raises an interrupt request when a chosen edge appears on any of them. Each pin owns three control bits held in the block: an edge/pull selector, an interrupt mask bit and a sticky event flag. The selector has two jobs. It names the edge that counts: 1 picks rising, 0 picks falling. It also steers the pin's weak bias device: 1 asks for a pull-down, 0 for a pull-up. The bias device is requested only while that pin's external pull-enable is high and the pin is an input.

Pin levels pass through a two-stage synchronizer. An edge is found by comparing the synchronized level with the level it had one clock earlier. Pins whose direction bit marks them as outputs never record events. Software reaches the three registers over a simple synchronous bus with a registered read path. It clears event flags by writing ones to them. The block drives a single registered request line, which is high while any flagged pin is also unmasked.

Top module: `pcint_top`

## Requirements
- R1: After reset, the selector, mask and flag registers read 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: For an input pin whose selector bit is 1, a rising edge on the pin sets its flag on the third rising clock edge after the pin changes. A falling edge on that pin sets nothing.
- R3: For an input pin whose selector bit is 0, a falling edge sets its flag, with the same latency as R2. A rising edge on that pin sets nothing.
- R4: A pin whose `dir_i` bit is 1 (output) never sets its flag, whatever edges it sees.
- R5: `pull_dn_o[i]` = `pull_en_i[i]` AND NOT `dir_i[i]` AND selector[i], and `pull_up_o[i]` = `pull_en_i[i]` AND NOT `dir_i[i]` AND NOT selector[i]. The two are never both 1.
- R6: `irq_o` is registered. In each cycle it equals the OR, over all pins, of (flag AND mask) as they stood one cycle earlier. A masked flag therefore never raises the request.
- R7: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it unchanged. If a new edge for a pin arrives in the same cycle as a clear of that pin's flag, the flag stays set.
- R8: Changing a selector bit while the pin level is steady never sets a flag.
- R9: The register map on `addr_i` is: 0 = selector, 1 = mask, 2 = flag (write 1 to clear), 3 = unused. Address 3 reads 0 and ignores writes. A read with `rd_en_i` high loads `rdata_o` at that clock edge with the register value from before any write in the same cycle. `rdata_o` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw pin levels |
| dir_i | input | 8 | Direction per pin, 1 = output |
| pull_en_i | input | 8 | Pull device enable per pin |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pull_up_o | output | 8 | Pull-up request per pin |
| pull_dn_o | output | 8 | Pull-down request per pin |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The bench aims at four corner cases. First, it times a clear so that it lands in the same cycle as a new edge: a design that let the clear win would lose that event. Second, it flips selector bits while the pins sit still: a design that compared polarity-adjusted samples would flag a false edge there. Third, it toggles pins set as outputs, and it toggles pins of both polarities in the direction that should be ignored: a design that got this wrong would set flags on edges that must not count. Fourth, it checks the request latency and masking cycle by cycle, so a design with an extra or missing register stage, or one that leaks masked flags, disagrees with the reference model on the exact clock.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    localparam int unsigned PC_ADDR_W = 2;

    typedef enum logic [PC_ADDR_W-1:0] {
        SEL_EDGE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_EVENT = 2'd2,
        SEL_NONE  = 2'd3
    } pc_sel_e;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcint_edge.sv
module pcint_edge #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] rise_sel_i,
    input  logic [WIDTH-1:0] dir_i,
    output logic [WIDTH-1:0] hit_o
);
    typedef struct packed {
        logic [WIDTH-1:0] last;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [WIDTH-1:0] rose, fell;

    always_comb begin
        st_d      = st_q;
        st_d.last = level_i;
        rose      = level_i & ~st_q.last;
        fell      = ~level_i & st_q.last;
        for (int i = 0; i < WIDTH; i++) begin
            hit_o[i] = !dir_i[i] && (rise_sel_i[i] ? rose[i] : fell[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcint_regs.sv
module pcint_regs
    import pcint_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [PC_ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]     wdata_i,
    input  logic [WIDTH-1:0]     hit_i,
    output logic [WIDTH-1:0]     rise_sel_o,
    output logic [WIDTH-1:0]     mask_o,
    output logic [WIDTH-1:0]     event_o,
    output logic [WIDTH-1:0]     rdata_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [WIDTH-1:0] rise_sel;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] events;
        logic [WIDTH-1:0] rdata;
        logic             irq;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [WIDTH-1:0] clr;
    pc_sel_e sel;

    always_comb begin
        st_d = st_q;
        sel  = pc_sel_e'(addr_i);
        clr  = '0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_EDGE:  st_d.rise_sel = wdata_i;
                SEL_MASK:  st_d.mask     = wdata_i;
                SEL_EVENT: clr           = wdata_i;
                default:   ;
            endcase
        end
        if (rd_en_i) begin
            unique case (sel)
                SEL_EDGE:  st_d.rdata = st_q.rise_sel;
                SEL_MASK:  st_d.rdata = st_q.mask;
                SEL_EVENT: st_d.rdata = st_q.events;
                default:   st_d.rdata = '0;
            endcase
        end
        st_d.events = (st_q.events & ~clr) | hit_i;
        st_d.irq    = |(st_q.events & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_sel_o = st_q.rise_sel;
    assign mask_o     = st_q.mask;
    assign event_o    = st_q.events;
    assign rdata_o    = st_q.rdata;
    assign irq_o      = st_q.irq;
endmodule

// File: rtl/pcint_top.sv
module pcint_top
    import pcint_pkg::*;
#(
    parameter int unsigned PINS       = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PINS-1:0]      pin_i,
    input  logic [PINS-1:0]      dir_i,
    input  logic [PINS-1:0]      pull_en_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [PC_ADDR_W-1:0] addr_i,
    input  logic [PINS-1:0]      wdata_i,
    output logic [PINS-1:0]      rdata_o,
    output logic [PINS-1:0]      pull_up_o,
    output logic [PINS-1:0]      pull_dn_o,
    output logic                 irq_o
);
    logic [PINS-1:0] level_w;
    logic [PINS-1:0] hit_w;
    logic [PINS-1:0] rise_sel_w;
    logic [PINS-1:0] mask_w;
    logic [PINS-1:0] event_w;
    logic [PINS-1:0] bias_on;

    pcint_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (level_w)
    );

    pcint_edge #(.WIDTH(PINS)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (level_w),
        .rise_sel_i (rise_sel_w),
        .dir_i      (dir_i),
        .hit_o      (hit_w)
    );

    pcint_regs #(.WIDTH(PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .hit_i      (hit_w),
        .rise_sel_o (rise_sel_w),
        .mask_o     (mask_w),
        .event_o    (event_w),
        .rdata_o    (rdata_o),
        .irq_o      (irq_o)
    );

    assign bias_on   = pull_en_i & ~dir_i;
    assign pull_dn_o = bias_on & rise_sel_w;
    assign pull_up_o = bias_on & ~rise_sel_w;
endmodule

// File: rtl/pcint_chk.sv
module pcint_chk
    import pcint_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PINS-1:0]      dir_i,
    input logic [PINS-1:0]      pull_en_i,
    input logic                 wr_en_i,
    input logic [PC_ADDR_W-1:0] addr_i,
    input logic [PINS-1:0]      wdata_i,
    input logic [PINS-1:0]      pull_up_o,
    input logic [PINS-1:0]      pull_dn_o,
    input logic                 irq_o,
    input logic [PINS-1:0]      event_w,
    input logic [PINS-1:0]      mask_w
);
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    // R5: never both bias devices on one pin
    p_bias_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up_o & pull_dn_o) == '0);

    // R5: bias only on enabled input pins
    p_bias_inputs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up_o | pull_dn_o) & (dir_i | ~pull_en_i)) == '0);

    // R6: request follows the masked flags one cycle later
    p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (irq_o == $past(|(event_w & mask_w))));

    // R4: a flag never becomes set for a pin that was an output
    p_output_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> ((event_w & ~$past(event_w) & $past(dir_i)) == '0));

    // R7: a flag drops only where a one was written to the flag register
    p_clear_only_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> ((~event_w & $past(event_w)
            & ~(($past(wr_en_i) && ($past(addr_i) == SEL_EVENT)) ? $past(wdata_i) : '0)) == '0));
endmodule

bind pcint_top pcint_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_i     (dir_i),
    .pull_en_i (pull_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pull_up_o (pull_up_o),
    .pull_dn_o (pull_dn_o),
    .irq_o     (irq_o),
    .event_w   (event_w),
    .mask_w    (mask_w)
);

// File: tb/tb_pcint_top.sv
`timescale 1ns/1ps
module tb_pcint_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0, dir_i = '0, pull_en_i = '0, wdata_i = '0;
    logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [1:0] addr_i = '0;
    logic [7:0] rdata_o, pull_up_o, pull_dn_o;
    logic       irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pcint_top dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_i(dir_i),
        .pull_en_i(pull_en_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o), .irq_o(irq_o)
    );

    // behavioural reference model
    logic [7:0] m_s1, m_s2, m_last, m_sel, m_mask, m_ev, m_rd;
    logic       m_irq;
    always @(posedge clk or negedge rst_n) begin
        logic [7:0] hit, clr;
        logic       nirq;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_last = 0; m_sel = 0; m_mask = 0;
            m_ev = 0; m_rd = 0; m_irq = 0;
        end else begin
            hit = '0;
            for (int i = 0; i < 8; i++)
                if (!dir_i[i] && m_s2[i] != m_last[i] && m_s2[i] == m_sel[i]) hit[i] = 1'b1;
            clr  = (wr_en_i && addr_i == 2) ? wdata_i : 8'h00;
            nirq = (m_ev & m_mask) != 0;
            if (rd_en_i) m_rd = (addr_i == 0) ? m_sel : (addr_i == 1) ? m_mask :
                                (addr_i == 2) ? m_ev : 8'h00;
            m_ev = (m_ev & ~clr) | hit;
            if (wr_en_i && addr_i == 0) m_sel  = wdata_i;
            if (wr_en_i && addr_i == 1) m_mask = wdata_i;
            m_last = m_s2; m_s2 = m_s1; m_s1 = pin_i; m_irq = nirq;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 irq vs model", {7'b0, irq_o}, {7'b0, m_irq});
            check("R9 rdata vs model", rdata_o, m_rd);
            check("R5 pull_dn vs model", pull_dn_o, pull_en_i & ~dir_i & m_sel);
            check("R5 pull_up vs model", pull_up_o, pull_en_i & ~dir_i & ~m_sel);
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr_i = a; rd_en_i = 1'b1;
        tick();
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        #1;
        check("R1 irq at reset", {7'b0, irq_o}, 8'h00);
        check("R1 rdata at reset", rdata_o, 8'h00);
        tick(2);
        rst_n = 1'b1;
        tick();
        rd(0, v); check("R1 selector reset", v, 8'h00);
        rd(1, v); check("R1 mask reset", v, 8'h00);
        rd(2, v); check("R1 flags reset", v, 8'h00);

        wr(1, 8'hFF);
        wr(0, 8'h0F);
        // R2 timing: rising on pin0 (sel=1), rising on pin4 (sel=0, ignored for R3)
        pin_i = 8'h11;
        tick(3);
        check("R6 irq not yet one cycle after flag", {7'b0, irq_o}, 8'h00);
        tick();
        check("R2 irq after rising edge", {7'b0, irq_o}, 8'h01);
        rd(2, v); check("R2 rising flagged, R3 rising ignored", v, 8'h01);
        pin_i = 8'h00;
        tick(5);
        rd(2, v); check("R3 falling flagged, R2 falling ignored", v, 8'h11);

        // R7 clear semantics
        wr(2, 8'h00);
        rd(2, v); check("R7 write zero keeps flags", v, 8'h11);
        wr(2, 8'h01);
        rd(2, v); check("R7 write one clears bit", v, 8'h10);
        wr(2, 8'h10);
        tick(2);
        rd(2, v); check("R7 all cleared", v, 8'h00);
        check("R6 irq drops after clear", {7'b0, irq_o}, 8'h00);
        // edge and clear in the same cycle
        pin_i = 8'h01;
        tick(2);
        wr(2, 8'h01);
        rd(2, v); check("R7 new edge beats clear", v, 8'h01);
        wr(2, 8'h01);
        rd(2, v); check("R7 clear after race", v, 8'h00);

        // R4 outputs never flag
        dir_i = 8'h04;
        pin_i = 8'h05; tick(5);
        pin_i = 8'h01; tick(5);
        rd(2, v); check("R4 output pin silent", v, 8'h00);
        dir_i = 8'h00;
        pin_i = 8'h05; tick(5);
        rd(2, v); check("R4 same pin flags as input", v, 8'h04);
        wr(2, 8'hFF);

        // R5 bias outputs
        pull_en_i = 8'hFF; dir_i = 8'h04;
        #1;
        check("R5 pull-down mapping", pull_dn_o, 8'h0B);
        check("R5 pull-up mapping", pull_up_o, 8'hF0);
        pull_en_i = 8'h00;
        #1;
        check("R5 no bias when disabled", pull_dn_o | pull_up_o, 8'h00);
        dir_i = 8'h00;

        // R8 selector change with steady pins
        tick(2);
        wr(0, 8'hF0); tick(5);
        wr(0, 8'h0F); tick(5);
        rd(2, v); check("R8 selector flip no flag", v, 8'h00);

        // R6 masking
        wr(1, 8'h00);
        wr(0, 8'h00);
        pin_i = 8'h00; tick(6);
        rd(2, v); check("R3 falls flagged under mask", v, 8'h05);
        check("R6 masked flags no request", {7'b0, irq_o}, 8'h00);
        wr(1, 8'h04);
        tick();
        check("R6 unmasked request", {7'b0, irq_o}, 8'h01);
        wr(1, 8'h00);
        tick();
        check("R6 remasked request", {7'b0, irq_o}, 8'h00);

        // R9 unused address
        wr(3, 8'hAA);
        rd(3, v); check("R9 unused reads zero", v, 8'h00);
        rd(0, v); check("R9 selector untouched", v, 8'h00);
        rd(1, v); check("R9 mask untouched", v, 8'h00);
        tick(3);
        check("R9 rdata holds", rdata_o, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule